// File: doc/BRIEF.md
# Receive Sync-Bit Position Marker

This block drives a single timing pin that shows where the sync bit of each received biphase line frame falls. It runs on the system clock and takes the receive bit timing as clock-enable ticks, one tick input per supported line rate. A rate select picks which tick stream sets the timing. The receive framer supplies a one-cycle sync flag that coincides with the tick of the bit it recognises as the frame sync bit, plus a level that says whether the receiver is synchronized. A mode input chooses between the framed network mode and the transparent modem mode.

The marker is high at all times while the receiver is unsynchronized. Once the receiver is synchronized it rests low and goes high for exactly one received bit, starting at the tick on which the framer flags the sync bit. In transparent modem mode the marker is inactive and held low. All inputs are plain control levels or single-cycle enables. There is no data stream and so no valid/ready handshake, and nothing can push back on the block.

Top module: `sync_mark_gen`

## Requirements
- R1: While the receiver is synchronized (rx_locked=1) and network mode is selected (modem_mode=0), the marker goes low in the clock cycle after a selected tick on which sync_flag is 0, and stays low until a sync flag arrives.
- R2: When modem_mode=1, sync_mark is 0 from the clock after the edge on which it is sampled, whatever the lock, flag and tick inputs are.
- R3: When rx_locked=0 in network mode, sync_mark is 1 from the clock after the edge on which it is sampled.
- R4: When a selected tick and sync_flag are both 1 on a clock edge, while locked and in network mode, sync_mark is 1 after that edge. It stays 1 through the next selected tick edge and no longer, so the pulse lasts exactly one tick period of the selected rate.
- R5: rate_sel is an index into bit_ticks. Index 0 is the 80 kbit/s tick and index 1 is the 160 kbit/s tick. Ticks on an unselected input neither start nor end a pulse.
- R6: A sync_flag that arrives on a clock with no selected tick has no effect on sync_mark.
- R7: A loss of lock drives sync_mark high one clock later, including in the middle of a pulse. It also clears any pulse in progress, so after lock returns the marker is low until the next flagged tick.
- R8: While rst_n=0, sync_mark equals the inverse of modem_mode: high in network mode and low in modem mode.
- R9: A sync flag on the same tick that would end a running pulse keeps sync_mark high without a gap, and starts a new one-tick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_ticks | input | NUM_RATES | One receive bit-clock enable per line rate; index 0 = 80 kbit/s, 1 = 160 kbit/s |
| rate_sel | input | RSW | Index of the active tick input |
| rx_locked | input | 1 | Receiver synchronized status bit |
| sync_flag | input | 1 | Framer strobe, high on the tick of the received sync bit |
| modem_mode | input | 1 | 1 = transparent modem mode, 0 = network mode |
| sync_mark | output | 1 | Sync-bit position marker |

## Verification
Two functions can land in the same cycle. One is the end of a running pulse, which falls on a selected tick. The other is the start of a new pulse, or a loss of lock. The bench flags the sync bit on the very tick that closes the previous pulse and expects an unbroken high level one tick longer. It also drops lock on a flagged tick and expects the marker to stay high, and then to fall to low, not to a leftover pulse, once lock returns. A reference model in the scoreboard predicts every cycle of these sequences at both rates.

// File: rtl/sync_mark_pkg.sv
package sync_mark_pkg;
  typedef enum logic {
    MODE_NETWORK = 1'b0,
    MODE_MODEM   = 1'b1
  } line_mode_e;

  typedef enum logic [1:0] {
    MARK_RESET,
    MARK_OFF,
    MARK_HUNT,
    MARK_TRACK
  } mark_state_e;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sm_tick_sel.sv
module sm_tick_sel #(
  parameter int NUM_RATES = 2,
  localparam int RSW = sync_mark_pkg::sel_width(NUM_RATES)
) (
  input  logic [NUM_RATES-1:0] bit_ticks,
  input  logic [RSW-1:0]       rate_sel,
  output logic                 tick
);
  logic [NUM_RATES-1:0] hit;

  // one decoder leg per rate; an out-of-range index selects nothing
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_leg
    assign hit[g] = bit_ticks[g] && (rate_sel == RSW'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/sm_pulse_track.sv
module sm_pulse_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_flag,
  input  logic active,
  output logic pulse
);
  // pulse is re-decided on every selected tick: flagged tick -> one bit high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pulse <= 1'b0;
    else if (!active) pulse <= 1'b0;
    else if (tick)    pulse <= sync_flag;
  end
endmodule

// File: rtl/sm_out_stage.sv
module sm_out_stage
  import sync_mark_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_locked,
  input  logic modem_mode,
  input  logic pulse,
  output logic sync_mark
);
  logic        lock_q;
  line_mode_e  mode_q;
  mark_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      mode_q <= MODE_NETWORK;
    end else begin
      lock_q <= rx_locked;
      mode_q <= line_mode_e'(modem_mode);
    end
  end

  always_comb begin
    if (!rst_n)                  state = MARK_RESET;
    else if (mode_q == MODE_MODEM) state = MARK_OFF;
    else if (!lock_q)            state = MARK_HUNT;
    else                         state = MARK_TRACK;
  end

  always_comb begin
    unique case (state)
      MARK_RESET: sync_mark = !modem_mode;
      MARK_OFF:   sync_mark = 1'b0;
      MARK_HUNT:  sync_mark = 1'b1;
      default:    sync_mark = pulse;
    endcase
  end
endmodule

// File: rtl/sync_mark_gen.sv
module sync_mark_gen #(
  parameter int NUM_RATES = 2,
  localparam int RSW = sync_mark_pkg::sel_width(NUM_RATES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] bit_ticks,
  input  logic [RSW-1:0]       rate_sel,
  input  logic                 rx_locked,
  input  logic                 sync_flag,
  input  logic                 modem_mode,
  output logic                 sync_mark
);
  logic tick;
  logic pulse;
  logic active;

  assign active = rx_locked && !modem_mode;

  sm_tick_sel #(.NUM_RATES(NUM_RATES)) u_sel (
    .bit_ticks (bit_ticks),
    .rate_sel  (rate_sel),
    .tick      (tick)
  );

  sm_pulse_track u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sync_flag (sync_flag),
    .active    (active),
    .pulse     (pulse)
  );

  sm_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_locked  (rx_locked),
    .modem_mode (modem_mode),
    .pulse      (pulse),
    .sync_mark  (sync_mark)
  );
endmodule

// File: rtl/sync_mark_gen_chk.sv
module sync_mark_gen_chk #(
  parameter int NUM_RATES = 2,
  localparam int RSW = sync_mark_pkg::sel_width(NUM_RATES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RATES-1:0] bit_ticks,
  input logic [RSW-1:0]       rate_sel,
  input logic                 rx_locked,
  input logic                 sync_flag,
  input logic                 modem_mode,
  input logic                 sync_mark
);
  logic sel_t;
  always_comb begin
    sel_t = 1'b0;
    for (int i = 0; i < NUM_RATES; i++)
      if (rate_sel == RSW'(i)) sel_t = bit_ticks[i];
  end

  logic net_lock;
  assign net_lock = rx_locked && !modem_mode;

  a_r2_modem_low: assert property (@(posedge clk) disable iff (!rst_n)
    modem_mode |=> !sync_mark);

  a_r3_unlocked_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_locked && !modem_mode) |=> sync_mark);

  a_r4_flag_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (net_lock && sel_t && sync_flag) |=> sync_mark);

  a_r1_unflagged_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
    (net_lock && sel_t && !sync_flag) |=> !sync_mark);

  // R6: between selected ticks the marker holds while lock and mode persist
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (net_lock && !sel_t && $past(net_lock) && $past(rst_n)) |=> $stable(sync_mark));
endmodule

bind sync_mark_gen sync_mark_gen_chk #(.NUM_RATES(NUM_RATES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_ticks  (bit_ticks),
  .rate_sel   (rate_sel),
  .rx_locked  (rx_locked),
  .sync_flag  (sync_flag),
  .modem_mode (modem_mode),
  .sync_mark  (sync_mark)
);

// File: tb/sync_mark_gen_bench.sv
module sync_mark_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bit_ticks = '0;
  logic [0:0] rate_sel = '0;
  logic       rx_locked = 1'b0;
  logic       sync_flag = 1'b0;
  logic       modem_mode = 1'b0;
  logic       sync_mark;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic  q_exp[$];
  string q_req[$];
  logic  m_pulse = 1'b0;

  always #2 clk = ~clk;

  sync_mark_gen u_sync_mark_gen (
    .clk(clk), .rst_n(rst_n), .bit_ticks(bit_ticks), .rate_sel(rate_sel),
    .rx_locked(rx_locked), .sync_flag(sync_flag), .modem_mode(modem_mode),
    .sync_mark(sync_mark)
  );

  task automatic check(input logic act, input logic exp, input string rq);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sync_mark=%b expected %b", rq, act, exp);
    end
  endtask

  // driver: apply one cycle of inputs and push the predicted marker level
  task automatic step(input logic tf, input logic ts, input logic st,
                      input logic lk, input logic md, input logic rt,
                      input string rq);
    logic sel;
    logic exp;
    @(negedge clk);
    bit_ticks  = {tf, ts};
    sync_flag  = st;
    rx_locked  = lk;
    modem_mode = md;
    rate_sel   = rt;
    sel = rt ? tf : ts;
    if (!lk || md) m_pulse = 1'b0;
    else if (sel)  m_pulse = st;
    exp = md ? 1'b0 : (!lk ? 1'b1 : m_pulse);
    q_exp.push_back(exp);
    q_req.push_back(rq);
  endtask

  // fast tick every 4 clocks, slow tick every 8; flags at cycles s1 and s2
  task automatic run(input int n, input logic lk, input logic md, input logic rt,
                     input int s1, input int s2, input string rq);
    for (int c = 0; c < n; c++)
      step((c % 4) == 3, (c % 8) == 7, (c == s1) || (c == s2), lk, md, rt, rq);
  endtask

  // monitor: pop and compare just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic  e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        check(sync_mark, e, r);
      end
    end
  end

  initial begin
    #1;
    check(sync_mark, 1'b1, "R8 network reset");
    modem_mode = 1'b1;
    #1;
    check(sync_mark, 1'b0, "R8 modem reset");
    modem_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    run(16, 1'b0, 1'b0, 1'b1, 7, -1, "R3 unlocked");
    run(16, 1'b1, 1'b0, 1'b1, -1, -1, "R1 locked idle");
    run(32, 1'b1, 1'b0, 1'b1, 11, -1, "R4 fast pulse");
    run(32, 1'b1, 1'b0, 1'b0, 15, -1, "R4 slow pulse");
    run(32, 1'b1, 1'b0, 1'b0, 11, -1, "R5 unselected tick");
    run(32, 1'b1, 1'b0, 1'b1, 5, -1, "R6 flag off tick");
    run(32, 1'b1, 1'b0, 1'b1, 11, 15, "R9 fast back-to-back");
    run(40, 1'b1, 1'b0, 1'b0, 7, 15, "R9 slow back-to-back");
    run(24, 1'b1, 1'b1, 1'b1, 11, -1, "R2 modem locked");
    run(16, 1'b0, 1'b1, 1'b0, 7, -1, "R2 modem unlocked");

    // R7: lock lost mid-pulse, then relock without a flag
    run(13, 1'b1, 1'b0, 1'b1, 11, -1, "R7 pre");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 drop mid-pulse");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 unlocked");
    run(12, 1'b1, 1'b0, 1'b1, -1, -1, "R7 relock cleared");
    // R7: lock lost on the flagged tick itself
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7 drop on flag");
    run(12, 1'b1, 1'b0, 1'b1, -1, -1, "R7 relock after flag");

    while (q_exp.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule